// File: doc/BRIEF.md
# Byte-Wide GPIO Port with Edge Interrupts

This block is one eight-line general-purpose I/O port attached to a byte-wide memory-mapped register bus. Software sets per-line direction and output level, reads the synchronized pad levels, and can hand any line to an on-chip peripheral. Each line also has an edge detector. The detector sets a per-line interrupt flag on a rising or falling edge, chosen per line.

The port decodes seven byte registers at offsets 0 to 6 from a base address parameter. A second instance of the port is placed 8 bytes higher by giving it a different base. The offsets are: 0 input level (read-only), 1 output level, 2 direction, 3 interrupt flags, 4 edge polarity, 5 interrupt enable, 6 function select. The enabled flags of all lines are ORed into one registered interrupt request for the port. There is no sequencing state machine. All behaviour is per-cycle register update and combinational pad steering, with an enumerated register index decoded from the address.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `pad_oe` is all 0 while function select is 0.
- R2: Offsets 1 to 6 above `BASE_ADDR` are read/write: a byte written at an offset reads back unchanged at the same offset. A read happens when `bus_sel`=1 and `bus_wr`=0. A write is taken on the clock edge where `bus_sel`=1 and `bus_wr`=1.
- R3: Offset 0 is read-only: a write to it changes no register, and it keeps returning the pad level.
- R4: Addresses outside `BASE_ADDR`..`BASE_ADDR`+6 (offset 7 included) read as 0, and writes to them change no register.
- R5: With function select bit i at 0, `pad_oe[i]` equals direction bit i. `pad_out[i]` equals output bit i.
- R6: With function select bit i at 1, `pad_oe[i]` equals `alt_oe[i]` and `pad_out[i]` equals `alt_out[i]`, whatever the direction and output bits hold.
- R7: With edge polarity bit i at 0, a low-to-high change of `pad_in[i]` sets flag bit i. With the bit at 1, a high-to-low change sets it. The opposite edge leaves the flag unchanged. The flag is set on the third clock edge after the pad change.
- R8: Writing the flag register loads it. A 0 bit clears a flag and a 1 bit sets it. When an edge is detected on the same clock edge as a clearing write, that flag ends up set.
- R9: `irq` is the OR over all lines of (flag AND enable), registered, so it follows the flag register one clock later.
- R10: Each pad input passes through two flip-flops. Offset 0 shows a pad change after exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, combinational, 0 when not selected |
| pad_in | input | W | Pad input levels |
| pad_out | output | W | Pad output levels |
| pad_oe | output | W | Pad output enables (0 = high impedance) |
| alt_out | input | W | Peripheral output levels |
| alt_oe | input | W | Peripheral output enables |
| irq | output | 1 | Combined port interrupt request |

## Verification
A wrong flag or edge-detector state shows at the ports as a flag byte read at offset 3, three clocks after the pad change. `irq` then shows it one clock later. A wrong synchronizer depth shows as an offset-0 read that changes one edge early or late. A wrong polarity shows up when each line is swept with each edge and each polarity setting. A decode or steering fault shows at once on `bus_rdata`, `pad_out` or `pad_oe`, in the same cycle as the register write that exposes it.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Register index; the numeric value is the byte offset from the base.
    typedef enum logic [2:0] {
        IDX_LEVEL = 3'd0,
        IDX_DRIVE = 3'd1,
        IDX_DIR   = 3'd2,
        IDX_FLAG  = 3'd3,
        IDX_POL   = 3'd4,
        IDX_IEN   = 3'd5,
        IDX_FSEL  = 3'd6,
        IDX_NONE  = 3'd7
    } gpio_idx_e;

    function automatic gpio_idx_e idx_decode(input logic in_window, input logic [2:0] off);
        if (!in_window) return IDX_NONE;
        return gpio_idx_e'(off);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] fall_sel,
    output logic [W-1:0] edge_hit
);
    logic [W-1:0] level_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_d <= '0;
        else        level_d <= level;
    end

    for (genvar i = 0; i < W; i++) begin : g_lane
        always_comb begin
            if (fall_sel[i]) edge_hit[i] = level_d[i] & ~level[i];
            else             edge_hit[i] = ~level_d[i] & level[i];
        end
    end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_port_pkg::*;
#(
    parameter int             W         = 8,
    parameter int             AW        = 8,
    parameter logic [AW-1:0]  BASE_ADDR = 'h40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  level,
    input  logic [W-1:0]  edge_hit,
    output logic [W-1:0]  drive_q,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  flag_q,
    output logic [W-1:0]  pol_q,
    output logic [W-1:0]  ien_q,
    output logic [W-1:0]  fsel_q
);
    localparam int unsigned NREGS = 7;

    logic [AW-1:0] off;
    logic          in_window;
    gpio_idx_e     idx;
    logic          wr_en;

    assign off       = bus_addr - BASE_ADDR;
    assign in_window = (off < AW'(NREGS));
    assign idx       = idx_decode(in_window, off[2:0]);
    assign wr_en     = bus_sel & bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= '0;
            dir_q   <= '0;
            pol_q   <= '0;
            ien_q   <= '0;
            fsel_q  <= '0;
        end else if (wr_en) begin
            unique case (idx)
                IDX_DRIVE: drive_q <= bus_wdata;
                IDX_DIR:   dir_q   <= bus_wdata;
                IDX_POL:   pol_q   <= bus_wdata;
                IDX_IEN:   ien_q   <= bus_wdata;
                IDX_FSEL:  fsel_q  <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // Flag register: a software load, then detected edges OR in on top.
    logic [W-1:0] flag_base;
    always_comb begin
        flag_base = flag_q;
        if (wr_en && idx == IDX_FLAG) flag_base = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_base | edge_hit;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (idx)
                IDX_LEVEL: bus_rdata = level;
                IDX_DRIVE: bus_rdata = drive_q;
                IDX_DIR:   bus_rdata = dir_q;
                IDX_FLAG:  bus_rdata = flag_q;
                IDX_POL:   bus_rdata = pol_q;
                IDX_IEN:   bus_rdata = ien_q;
                IDX_FSEL:  bus_rdata = fsel_q;
                IDX_NONE:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
    parameter int             W         = 8,
    parameter int             AW        = 8,
    parameter logic [AW-1:0]  BASE_ADDR = 'h40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe,
    input  logic [W-1:0]  alt_out,
    input  logic [W-1:0]  alt_oe,
    output logic          irq
);
    logic [W-1:0] level;
    logic [W-1:0] edge_hit;
    logic [W-1:0] drive_q, dir_q, flag_q, pol_q, ien_q, fsel_q;

    gpio_sync #(.W(W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (level)
    );

    gpio_edge_detect #(.W(W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level),
        .fall_sel (pol_q),
        .edge_hit (edge_hit)
    );

    gpio_regfile #(.W(W), .AW(AW), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .level     (level),
        .edge_hit  (edge_hit),
        .drive_q   (drive_q),
        .dir_q     (dir_q),
        .flag_q    (flag_q),
        .pol_q     (pol_q),
        .ien_q     (ien_q),
        .fsel_q    (fsel_q)
    );

    for (genvar i = 0; i < W; i++) begin : g_pad
        assign pad_out[i] = fsel_q[i] ? alt_out[i] : drive_q[i];
        assign pad_oe[i]  = fsel_q[i] ? alt_oe[i]  : dir_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flag_q & ien_q);
    end
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
    parameter int             W         = 8,
    parameter int             AW        = 8,
    parameter logic [AW-1:0]  BASE_ADDR = 'h40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  pad_in,
    input logic          irq,
    input logic [W-1:0]  level,
    input logic [W-1:0]  edge_hit,
    input logic [W-1:0]  flag_q,
    input logic [W-1:0]  ien_q
);
    logic       wr_flag;
    logic [1:0] settle;

    assign wr_flag = bus_sel & bus_wr & (bus_addr == BASE_ADDR + AW'(3));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            settle <= 2'd0;
        else if (settle != 2'd3) settle <= settle + 2'd1;
    end

    p_irq_low_at_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq);

    p_edge_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_hit) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit)));

    p_flag_set_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        settle != 2'd0 |-> ((flag_q & ~$past(flag_q) & ~$past(edge_hit)
                  & ~($past(wr_flag) ? $past(bus_wdata) : '0)) == '0));

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|flag_q));

    p_irq_off_when_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        settle != 2'd0 && $past(ien_q) == '0 |-> !irq);

    p_sync_two_edges_r10: assert property (@(posedge clk) disable iff (!rst_n)
        settle == 2'd3 |-> level == $past(pad_in, 2));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.W(W), .AW(AW), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_in    (pad_in),
    .irq       (irq),
    .level     (level),
    .edge_hit  (edge_hit),
    .flag_q    (flag_q),
    .ien_q     (ien_q)
);

// File: tb/gpio_edge_port_bench.sv
module gpio_edge_port_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          W          = 8;
    localparam int          AW         = 8;
    localparam logic [7:0]  BASE       = 8'h40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pad_in = '0;
    logic [W-1:0]  pad_out, pad_oe;
    logic [W-1:0]  alt_out = '0;
    logic [W-1:0]  alt_oe = '0;
    logic          irq;

    int  total = 0;
    int  bad = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_port #(.W(W), .AW(AW), .BASE_ADDR(BASE)) u_gpio_edge_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called in the negedge phase; returns in the negedge phase.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1; d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        rd(a, v);
        check(v === e, req, v, e);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int k = 0; k < 7; k++) expect_reg(BASE + 8'(k), 8'h00, "R1");
        check(irq === 1'b0, "R1 irq", irq, 0);
        check(pad_oe === 8'h00, "R1 pad_oe", pad_oe, 0);

        // R2: read/write round trip at offsets 1..6 (flag offset 3 too)
        for (int k = 1; k < 7; k++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] pat;
                pat = 8'((k * 37 + p * 91) ^ (p * 8'h5A));
                wr(BASE + 8'(k), pat);
                expect_reg(BASE + 8'(k), pat, "R2");
            end
            wr(BASE + 8'(k), 8'h00);
            expect_reg(BASE + 8'(k), 8'h00, "R2 clear");
        end
        @(negedge clk);

        // R4: out-of-window accesses
        wr(BASE + 8'd7, 8'hFF);
        wr(BASE - 8'd1, 8'hFF);
        wr(BASE + 8'd8, 8'hFF);
        expect_reg(BASE + 8'd7, 8'h00, "R4 read offset 7");
        expect_reg(BASE - 8'd1, 8'h00, "R4 read below");
        expect_reg(BASE + 8'd8, 8'h00, "R4 read above");
        for (int k = 1; k < 7; k++) expect_reg(BASE + 8'(k), 8'h00, "R4 untouched");

        // R10 and R3: sync depth, offset 0 read-only
        for (int n = 1; n < 256; n++) begin
            logic [7:0] prev;
            prev = pad_in;
            pad_in = 8'(n * 53);
            @(posedge clk); @(negedge clk);
            expect_reg(BASE, prev, "R10 one edge");
            @(posedge clk); @(negedge clk);
            expect_reg(BASE, 8'(n * 53), "R10 two edges");
            if (n % 32 == 0) begin
                wr(BASE, ~pad_in);
                expect_reg(BASE, pad_in, "R3 write ignored");
                for (int k = 1; k < 7; k++)
                    if (k != 3) expect_reg(BASE + 8'(k), 8'h00, "R3 no side effect");
            end
        end
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        wr(BASE + 8'd3, 8'h00);

        // R5 / R6: pad steering sweep
        for (int n = 0; n < 64; n++) begin
            logic [7:0] d, o, s;
            d = 8'(n * 29); o = 8'(n * 71 + 3); s = 8'(n * 13 + 5);
            alt_out = 8'(n * 151); alt_oe = 8'(~(n * 19));
            wr(BASE + 8'd1, o);
            wr(BASE + 8'd2, d);
            wr(BASE + 8'd6, (n % 2 == 0) ? 8'h00 : s);
            if (n % 2 == 0) begin
                check(pad_oe === d, "R5 oe", pad_oe, d);
                check(pad_out === o, "R5 out", pad_out, o);
            end else begin
                check(pad_oe === ((s & alt_oe) | (~s & d)), "R6 oe", pad_oe, (s & alt_oe) | (~s & d));
                check(pad_out === ((s & alt_out) | (~s & o)), "R6 out", pad_out, (s & alt_out) | (~s & o));
            end
        end
        wr(BASE + 8'd1, 8'h00); wr(BASE + 8'd2, 8'h00); wr(BASE + 8'd6, 8'h00);

        // R7 / R9: every lane, every polarity, both edges
        for (int p = 0; p < 8; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
                logic [7:0] m;
                m = 8'(1 << p);
                wr(BASE + 8'd4, pol ? m : 8'h00);
                wr(BASE + 8'd5, pol ? 8'h00 : m);
                wr(BASE + 8'd3, 8'h00);
                pad_in = m;
                repeat (3) @(posedge clk);
                @(negedge clk);
                expect_reg(BASE + 8'd3, pol ? 8'h00 : m, "R7 rising");
                check(irq === 1'b0, "R9 irq not yet", irq, 0);
                @(posedge clk); @(negedge clk);
                check(irq === (pol ? 1'b0 : 1'b1), "R9 irq one later", irq, pol ? 0 : 1);
                wr(BASE + 8'd3, 8'h00);
                @(posedge clk); @(negedge clk);
                check(irq === 1'b0, "R9 irq cleared", irq, 0);
                pad_in = 8'h00;
                repeat (3) @(posedge clk);
                @(negedge clk);
                expect_reg(BASE + 8'd3, pol ? m : 8'h00, "R7 falling");
                wr(BASE + 8'd3, 8'h00);
            end
        end
        wr(BASE + 8'd4, 8'h00); wr(BASE + 8'd5, 8'h00);

        // R8: set by write, edge wins over a same-edge clear
        for (int p = 0; p < 8; p++) begin
            logic [7:0] m, q;
            m = 8'(1 << p); q = 8'(1 << ((p + 3) % 8));
            wr(BASE + 8'd3, m | q);
            expect_reg(BASE + 8'd3, m | q, "R8 write sets");
            pad_in = m;
            @(posedge clk); @(posedge clk); @(negedge clk);
            wr(BASE + 8'd3, 8'h00);
            expect_reg(BASE + 8'd3, m, "R8 edge beats clear");
            pad_in = 8'h00;
            repeat (3) @(negedge clk);
            wr(BASE + 8'd3, 8'h00);
            expect_reg(BASE + 8'd3, 8'h00, "R8 clear");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule